// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Engine

This block moves long-word data between host memory and a device FIFO under the control of a chain of descriptors held in memory. Software writes the byte address of the first descriptor to the start port. The engine then reads that descriptor as a three-word burst. It drops the bus and performs the data bursts the descriptor calls for. It then fetches the next descriptor and repeats until a descriptor marked as last has finished.

The memory side is a simple request/grant master. A beat completes in any cycle where the engine signals a beat while it holds the grant. Read data returns in the same cycle, and write data is taken at the clock edge. The FIFO side uses first-word-fall-through reads from a source FIFO when the channel moves data into memory. It uses plain writes into a destination FIFO when the channel moves data out of memory. An almost-empty flag or an almost-full flag pauses the burst.

The engine gives up the bus at every boundary the requirements list, and after a fixed maximum tenure. Completion and error are reported through two sticky flags that are cleared by writing a one.

Top module: `sgdma_engine`

## Requirements
- R1: A pulse on `start_wr` while idle raises `busy` and `bus_req`. The first three beats then read the words at `start_addr`, `start_addr+4` and `start_addr+8`, with `mem_we` low.
- R2: Descriptor layout:
  - word 0 is the buffer byte address.
  - word 1 bits LEN_W-1:0 are the length in long words.
  - word 2 bit 0 is end-of-chain (1 = last).
  - word 2 bit 1 is direction (1 = memory to device, 0 = device to memory), using the same encoding as `chan_dir`.
  - word 2 bits 31:2 are the next descriptor address.
- R3: `bus_req` falls for at least one cycle after every descriptor fetch and at the end of every buffer. A single-descriptor transfer with no stalls therefore shows exactly two request periods.
- R4: Device to memory: each beat writes the current source FIFO word to the next consecutive buffer address. No beat occurs while `src_aempty` is high, and the request is released until the flag falls.
- R5: Memory to device: each beat pushes the word read from the next consecutive buffer address into the destination FIFO. No push occurs while `dst_afull` is high, and the request is released until the flag falls.
- R6: `bus_req` together with `bus_gnt` stays high for at most TENURE_MAX consecutive cycles. After that the request drops and the transfer resumes where it stopped.
- R7: A target or master abort on a beat sets `err_flag`, ends the whole transfer (`busy` falls) and moves no data on that beat.
- R8: A descriptor whose direction bit differs from `chan_dir` sets `err_flag`, ends the transfer and causes no data beats.
- R9: `done_flag` sets when the last descriptor finishes. `stat_clr` bit 0 clears `done_flag` and bit 1 clears `err_flag`. Each flag is unaffected by the other bit.
- R10: A `start_wr` pulse while `busy` is high is ignored. The running chain continues unchanged.
- R11: A descriptor of length zero causes no data beats. The engine goes on to the next descriptor, or sets `done_flag` if the zero-length descriptor is the last one.
- R12: After reset, `busy`, `bus_req`, `done_flag` and `err_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Start port write strobe |
| start_addr | input | 32 | First descriptor byte address |
| chan_dir | input | 1 | Channel direction, 1 = memory to device |
| stat_clr | input | 2 | Write-one-to-clear: bit 0 done, bit 1 error |
| busy | output | 1 | Engine is walking a chain |
| done_flag | output | 1 | Sticky list-complete flag |
| err_flag | output | 1 | Sticky DMA error flag |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | 32 | Beat byte address |
| mem_beat | output | 1 | A beat completes this cycle |
| mem_we | output | 1 | Beat is a memory write |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| abort_tgt | input | 1 | Target abort on the current beat |
| abort_mst | input | 1 | Master abort on the current beat |
| src_rd_en | output | 1 | Pop the source FIFO |
| src_rd_data | input | 32 | Source FIFO head word |
| src_aempty | input | 1 | Source FIFO almost empty |
| dst_wr_en | output | 1 | Push the destination FIFO |
| dst_wr_data | output | 32 | Destination FIFO write word |
| dst_afull | input | 1 | Destination FIFO almost full |

## Verification
The hardest case to reach is the tenure limit. It fires only on a buffer longer than 1024 beats, with the grant held and the FIFO flags quiet throughout. The stimulus builds an 1100-word device-to-memory descriptor and measures the longest unbroken granted run and the number of request periods. Aborts mid-burst are reached by having the memory model assert an abort on one chosen beat address. A start while busy is reached by aiming a second start at a descriptor that would raise a direction error if it were ever taken.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_GAP
    } sg_state_e;

    localparam logic [1:0] LAST_WORD_IDX = 2'd2;

    function automatic logic link_is_last(input logic [31:0] w);
        return w[0];
    endfunction

    function automatic logic link_dir(input logic [31:0] w);
        return w[1];
    endfunction

    function automatic logic [31:0] word_align(input logic [31:0] w);
        return {w[31:2], 2'b00};
    endfunction

endpackage

// File: rtl/sgdma_tenure.sv
module sgdma_tenure #(
    parameter int TENURE_MAX = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic gnt,
    output logic hit
);
    localparam int CW = $clog2(TENURE_MAX + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            cnt <= '0;
        end else if (gnt) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = req && gnt && (cnt == CW'(TENURE_MAX - 1));
endmodule

// File: rtl/sgdma_status.sv
module sgdma_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_done,
    input  logic       set_err,
    input  logic [1:0] clr,
    output logic       done_flag,
    output logic       err_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (set_done)    done_flag <= 1'b1;
            else if (clr[0]) done_flag <= 1'b0;
            if (set_err)     err_flag  <= 1'b1;
            else if (clr[1]) err_flag  <= 1'b0;
        end
    end
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
    import sgdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_wr,
    input  logic [31:0] start_addr,
    input  logic        chan_dir,
    input  logic        bus_gnt,
    input  logic [31:0] mem_rdata,
    input  logic        abort_any,
    input  logic        src_aempty,
    input  logic        dst_afull,
    input  logic        tenure_hit,
    output logic        bus_req,
    output logic        mem_beat,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic        data_xfer,
    output logic        ev_done,
    output logic        ev_err,
    output logic        busy
);
    sg_state_e        state;
    logic [1:0]       idx;
    logic [31:0]      desc_ptr;
    logic [31:0]      buf_addr;
    logic [LEN_W-1:0] remain;
    logic             last_q;
    logic             to_fetch;

    logic fifo_stop;
    logic abort_hit;
    logic fetch_end;
    logic dir_bad;
    logic data_end;

    assign fifo_stop = chan_dir ? dst_afull : src_aempty;
    assign bus_req   = (state == ST_FETCH) || (state == ST_DATA);
    assign busy      = (state != ST_IDLE);
    assign mem_beat  = bus_gnt && ((state == ST_FETCH) ||
                                   ((state == ST_DATA) && !fifo_stop));
    assign mem_we    = (state == ST_DATA) && !chan_dir;
    assign mem_addr  = (state == ST_FETCH) ? (desc_ptr + {28'd0, idx, 2'b00})
                                           : buf_addr;
    assign abort_hit = mem_beat && abort_any;
    assign data_xfer = mem_beat && (state == ST_DATA) && !abort_any;
    assign fetch_end = mem_beat && !abort_any && (state == ST_FETCH) &&
                       (idx == LAST_WORD_IDX);
    assign dir_bad   = link_dir(mem_rdata) != chan_dir;
    assign data_end  = data_xfer && (remain == LEN_W'(1));

    assign ev_err  = abort_hit || (fetch_end && dir_bad);
    assign ev_done = (fetch_end && !dir_bad && (remain == '0) &&
                      link_is_last(mem_rdata)) ||
                     (data_end && last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            desc_ptr <= '0;
            buf_addr <= '0;
            remain   <= '0;
            last_q   <= 1'b0;
            to_fetch <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_wr) begin
                        desc_ptr <= word_align(start_addr);
                        idx      <= '0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (abort_hit) begin
                        state <= ST_IDLE;
                    end else if (mem_beat) begin
                        idx <= idx + 1'b1;
                        if (idx == 2'd0) buf_addr <= word_align(mem_rdata);
                        if (idx == 2'd1) remain   <= mem_rdata[LEN_W-1:0];
                        if (fetch_end) begin
                            last_q   <= link_is_last(mem_rdata);
                            desc_ptr <= word_align(mem_rdata);
                            idx      <= '0;
                            if (dir_bad) begin
                                state <= ST_IDLE;
                            end else if (remain == '0) begin
                                to_fetch <= 1'b1;
                                state    <= link_is_last(mem_rdata) ? ST_IDLE : ST_GAP;
                            end else begin
                                to_fetch <= 1'b0;
                                state    <= ST_GAP;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (abort_hit) begin
                        state <= ST_IDLE;
                    end else if (data_xfer) begin
                        buf_addr <= buf_addr + 32'd4;
                        remain   <= remain - 1'b1;
                        if (data_end) begin
                            to_fetch <= 1'b1;
                            state    <= last_q ? ST_IDLE : ST_GAP;
                        end else if (tenure_hit) begin
                            state <= ST_GAP;
                        end
                    end else if (fifo_stop) begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (to_fetch)        state <= ST_FETCH;
                    else if (!fifo_stop) state <= ST_DATA;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
    parameter int LEN_W      = 16,
    parameter int TENURE_MAX = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_wr,
    input  logic [31:0] start_addr,
    input  logic        chan_dir,
    input  logic [1:0]  stat_clr,
    output logic        busy,
    output logic        done_flag,
    output logic        err_flag,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic [31:0] mem_addr,
    output logic        mem_beat,
    output logic        mem_we,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        abort_tgt,
    input  logic        abort_mst,
    output logic        src_rd_en,
    input  logic [31:0] src_rd_data,
    input  logic        src_aempty,
    output logic        dst_wr_en,
    output logic [31:0] dst_wr_data,
    input  logic        dst_afull
);
    logic tenure_hit;
    logic data_xfer;
    logic ev_done;
    logic ev_err;

    sgdma_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_wr   (start_wr),
        .start_addr (start_addr),
        .chan_dir   (chan_dir),
        .bus_gnt    (bus_gnt),
        .mem_rdata  (mem_rdata),
        .abort_any  (abort_tgt || abort_mst),
        .src_aempty (src_aempty),
        .dst_afull  (dst_afull),
        .tenure_hit (tenure_hit),
        .bus_req    (bus_req),
        .mem_beat   (mem_beat),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .data_xfer  (data_xfer),
        .ev_done    (ev_done),
        .ev_err     (ev_err),
        .busy       (busy)
    );

    sgdma_tenure #(.TENURE_MAX(TENURE_MAX)) u_tenure (
        .clk (clk),
        .rst (rst),
        .req (bus_req),
        .gnt (bus_gnt),
        .hit (tenure_hit)
    );

    sgdma_status u_status (
        .clk       (clk),
        .rst       (rst),
        .set_done  (ev_done),
        .set_err   (ev_err),
        .clr       (stat_clr),
        .done_flag (done_flag),
        .err_flag  (err_flag)
    );

    assign mem_wdata   = src_rd_data;
    assign dst_wr_data = mem_rdata;
    assign src_rd_en   = data_xfer && !chan_dir;
    assign dst_wr_en   = data_xfer && chan_dir;
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
    parameter int TENURE_MAX = 1024
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       mem_beat,
    input logic       mem_we,
    input logic       src_aempty,
    input logic       dst_wr_en,
    input logic       dst_afull,
    input logic       busy,
    input logic       done_flag,
    input logic       err_flag,
    input logic [1:0] stat_clr,
    input logic       abort_tgt,
    input logic       abort_mst
);
    int unsigned run_cnt;

    always_ff @(posedge clk) begin
        if (rst) run_cnt <= 0;
        else     run_cnt <= (bus_req && bus_gnt) ? run_cnt + 1 : 0;
    end

    AST_BEAT_GRANTED: assert property (@(posedge clk) disable iff (rst)
        mem_beat |-> (bus_req && bus_gnt)); // R1
    AST_REQ_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> busy); // R1
    AST_SRC_GUARD: assert property (@(posedge clk) disable iff (rst)
        (mem_beat && mem_we) |-> !src_aempty); // R4
    AST_DST_GUARD: assert property (@(posedge clk) disable iff (rst)
        dst_wr_en |-> !dst_afull); // R5
    AST_TENURE_CAP: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= TENURE_MAX); // R6
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
        (mem_beat && (abort_tgt || abort_mst)) |=> (err_flag && !busy)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !stat_clr[0]) |=> done_flag); // R9
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !stat_clr[1]) |=> err_flag); // R9
endmodule

bind sgdma_engine sgdma_engine_chk #(.TENURE_MAX(TENURE_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .mem_beat   (mem_beat),
    .mem_we     (mem_we),
    .src_aempty (src_aempty),
    .dst_wr_en  (dst_wr_en),
    .dst_afull  (dst_afull),
    .busy       (busy),
    .done_flag  (done_flag),
    .err_flag   (err_flag),
    .stat_clr   (stat_clr),
    .abort_tgt  (abort_tgt),
    .abort_mst  (abort_mst)
);

// File: tb/sgdma_engine_tb.sv
`timescale 1ns/1ps
module sgdma_engine_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_wr;
    logic [31:0] start_addr;
    logic        chan_dir;
    logic [1:0]  stat_clr;
    logic        busy, done_flag, err_flag, bus_req, bus_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_beat, mem_we, abort_tgt, abort_mst;
    logic        src_rd_en, src_aempty, dst_wr_en, dst_afull;
    logic [31:0] src_rd_data, dst_wr_data;

    logic        gnt_en, arm_tgt, arm_mst;
    logic [31:0] abort_at, watch_addr;
    logic [31:0] mem [0:2047];
    logic [31:0] src_cnt;
    logic [31:0] dst_q [0:63];
    int          dst_n, beat_n, req_rises, run, max_run, watch_hits;
    logic [31:0] beat_addr [0:15];
    logic        req_d;
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    sgdma_engine u_dut (
        .clk(clk), .rst(rst), .start_wr(start_wr), .start_addr(start_addr),
        .chan_dir(chan_dir), .stat_clr(stat_clr), .busy(busy),
        .done_flag(done_flag), .err_flag(err_flag), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_beat(mem_beat),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .abort_tgt(abort_tgt), .abort_mst(abort_mst), .src_rd_en(src_rd_en),
        .src_rd_data(src_rd_data), .src_aempty(src_aempty),
        .dst_wr_en(dst_wr_en), .dst_wr_data(dst_wr_data), .dst_afull(dst_afull)
    );

    assign bus_gnt     = bus_req && gnt_en;
    assign mem_rdata   = mem[mem_addr[12:2]];
    assign src_rd_data = 32'hC0DE_0000 + src_cnt;
    assign abort_tgt   = arm_tgt && mem_beat && (mem_addr == abort_at);
    assign abort_mst   = arm_mst && mem_beat && (mem_addr == abort_at);

    always @(posedge clk) begin
        if (mem_beat && mem_we) mem[mem_addr[12:2]] <= mem_wdata;
        if (rst) begin
            src_cnt <= 0; dst_n <= 0; beat_n <= 0; req_rises <= 0;
            run <= 0; max_run <= 0; watch_hits <= 0; req_d <= 1'b0;
        end else begin
            req_d <= bus_req;
            if (bus_req && !req_d) req_rises <= req_rises + 1;
            if (bus_req && bus_gnt) begin
                run <= run + 1;
                if (run + 1 > max_run) max_run <= run + 1;
            end else run <= 0;
            if (src_rd_en) src_cnt <= src_cnt + 1;
            if (dst_wr_en) begin
                if (dst_n < 64) dst_q[dst_n] <= dst_wr_data;
                dst_n <= dst_n + 1;
            end
            if (mem_beat) begin
                if (beat_n < 16) beat_addr[beat_n] <= mem_addr;
                beat_n <= beat_n + 1;
                if (mem_addr == watch_addr) watch_hits <= watch_hits + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; start_wr = 0; start_addr = 0; chan_dir = 0; stat_clr = 0;
        gnt_en = 1; arm_tgt = 0; arm_mst = 0; abort_at = 32'hFFFF_FFFF;
        watch_addr = 32'hFFFF_FFFF; src_aempty = 0; dst_afull = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] buffer,
                            input logic [31:0] len, input logic [31:0] nxt,
                            input logic dir, input logic last);
        mem[at[12:2]]     = buffer;
        mem[at[12:2] + 1] = len;
        mem[at[12:2] + 2] = {nxt[31:2], dir, last};
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk);
        start_wr = 1; start_addr = a;
        @(negedge clk);
        start_wr = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " idle"}, {31'd0, busy}, 32'd0);
    endtask

    // dir, length, buffer
    localparam logic [48:0] VEC [0:3] = '{
        {1'b0, 16'd5,  32'h0000_0200},
        {1'b1, 16'd7,  32'h0000_0300},
        {1'b0, 16'd1,  32'h0000_0400},
        {1'b1, 16'd12, 32'h0000_0500}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R12 busy", {31'd0, busy}, 0);
        chk("R12 req", {31'd0, bus_req}, 0);
        chk("R12 done", {31'd0, done_flag}, 0);
        chk("R12 err", {31'd0, err_flag}, 0);

        for (int k = 0; k < 4; k++) begin
            logic        d;
            logic [15:0] ln;
            logic [31:0] bf;
            {d, ln, bf} = VEC[k];
            do_reset();
            for (int i = 0; i < ln; i++) mem[bf[12:2] + i] = 32'h5A5A_0000 + (k << 8) + i;
            put_desc(32'h20, bf, {16'd0, ln}, 32'h0, d, 1'b1);
            chan_dir = d;
            kick(32'h20);
            chk("R1 busy after start", {31'd0, busy}, 1);
            wait_idle("R1");
            chk("R1 fetch addr0", beat_addr[0], 32'h20);
            chk("R1 fetch addr1", beat_addr[1], 32'h24);
            chk("R1 fetch addr2", beat_addr[2], 32'h28);
            chk("R2 beat count", beat_n, 3 + ln);
            chk("R3 request periods", req_rises, 2);
            chk("R9 done set", {31'd0, done_flag}, 1);
            for (int i = 0; i < ln; i++) begin
                if (d) chk("R5 pushed word", dst_q[i], 32'h5A5A_0000 + (k << 8) + i);
                else   chk("R4 stored word", mem[bf[12:2] + i], 32'hC0DE_0000 + i);
            end
        end

        // R11 zero-length link in a chain
        do_reset();
        put_desc(32'h40, 32'h0, 32'd0, 32'h60, 1'b1, 1'b0);
        put_desc(32'h60, 32'h600, 32'd2, 32'h0, 1'b1, 1'b1);
        mem[384] = 32'h1111_0001; mem[385] = 32'h1111_0002;
        chan_dir = 1;
        kick(32'h40);
        wait_idle("R11");
        chk("R11 beats", beat_n, 8);
        chk("R11 second fetch", beat_addr[3], 32'h60);
        chk("R11 first data addr", beat_addr[6], 32'h600);
        chk("R3 request periods chain", req_rises, 3);
        chk("R11 data", dst_q[1], 32'h1111_0002);
        chk("R11 done", {31'd0, done_flag}, 1);

        // R4 source almost empty stalls
        do_reset();
        put_desc(32'h20, 32'h700, 32'd10, 32'h0, 1'b0, 1'b1);
        chan_dir = 0; src_aempty = 1;
        kick(32'h20);
        repeat (20) @(negedge clk);
        chk("R4 no beats while aempty", beat_n, 3);
        chk("R4 request released", {31'd0, bus_req}, 0);
        chk("R4 still busy", {31'd0, busy}, 1);
        src_aempty = 0;
        repeat (4) @(negedge clk);
        src_aempty = 1;
        repeat (6) @(negedge clk);
        src_aempty = 0;
        wait_idle("R4");
        chk("R4 total beats", beat_n, 13);
        chk("R4 last word", mem[448 + 9], 32'hC0DE_0009);

        // R5 destination almost full stalls
        do_reset();
        put_desc(32'h20, 32'h800, 32'd6, 32'h0, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) mem[512 + i] = 32'h7700_0000 + i;
        chan_dir = 1; dst_afull = 1;
        kick(32'h20);
        repeat (15) @(negedge clk);
        chk("R5 no push while afull", dst_n, 0);
        dst_afull = 0;
        wait_idle("R5");
        chk("R5 pushes", dst_n, 6);
        chk("R5 word5", dst_q[5], 32'h7700_0005);

        // R6 tenure limit
        do_reset();
        put_desc(32'h20, 32'h400, 32'd1100, 32'h0, 1'b0, 1'b1);
        chan_dir = 0;
        kick(32'h20);
        wait_idle("R6");
        chk("R6 longest tenure", max_run, 1024);
        chk("R6 request periods", req_rises, 3);
        chk("R6 last word", mem[256 + 1099], 32'hC0DE_0000 + 1099);
        chk("R6 done", {31'd0, done_flag}, 1);

        // R7 target abort mid-burst
        do_reset();
        put_desc(32'h20, 32'h900, 32'd8, 32'h0, 1'b1, 1'b1);
        chan_dir = 1; arm_tgt = 1; abort_at = 32'h90C;
        kick(32'h20);
        wait_idle("R7");
        chk("R7 err", {31'd0, err_flag}, 1);
        chk("R7 no done", {31'd0, done_flag}, 0);
        chk("R7 pushes before abort", dst_n, 3);

        // R7 master abort during fetch
        do_reset();
        put_desc(32'h20, 32'h900, 32'd8, 32'h0, 1'b1, 1'b1);
        chan_dir = 1; arm_mst = 1; abort_at = 32'h24;
        kick(32'h20);
        wait_idle("R7m");
        chk("R7 master abort err", {31'd0, err_flag}, 1);
        chk("R7 master abort beats", beat_n, 2);
        // R9 clear error only
        @(negedge clk); stat_clr = 2'b10;
        @(negedge clk); stat_clr = 2'b00;
        chk("R9 err cleared", {31'd0, err_flag}, 0);

        // R8 direction mismatch
        do_reset();
        put_desc(32'h20, 32'h900, 32'd4, 32'h0, 1'b0, 1'b1);
        chan_dir = 1;
        kick(32'h20);
        wait_idle("R8");
        chk("R8 err", {31'd0, err_flag}, 1);
        chk("R8 beats", beat_n, 3);
        chk("R8 pushes", dst_n, 0);

        // R10 start while busy, then R9 clears
        do_reset();
        put_desc(32'h20, 32'hA00, 32'd20, 32'h0, 1'b1, 1'b1);
        put_desc(32'h100, 32'hB00, 32'd3, 32'h0, 1'b0, 1'b1);
        chan_dir = 1; watch_addr = 32'h100;
        kick(32'h20);
        repeat (5) @(negedge clk);
        kick(32'h100);
        wait_idle("R10");
        chk("R10 second desc untouched", watch_hits, 0);
        chk("R10 pushes", dst_n, 20);
        chk("R10 no err", {31'd0, err_flag}, 0);
        chk("R10 done", {31'd0, done_flag}, 1);
        @(negedge clk); stat_clr = 2'b10;
        @(negedge clk); stat_clr = 2'b00;
        chk("R9 done kept on err clear", {31'd0, done_flag}, 1);
        @(negedge clk); stat_clr = 2'b01;
        @(negedge clk); stat_clr = 2'b00;
        chk("R9 done cleared", {31'd0, done_flag}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule